// File: doc/BRIEF.md
# Double-Buffered Endpoint DMA Pacer

This block paces a local-bus DMA channel against one bulk endpoint whose FIFO holds two packet banks. It decides when the DMA request is raised, counts the words the DMA engine moves, and owns the endpoint's packet-ready status. Firmware therefore never has to set or clear that status itself. Serial signalling, CRC and token decoding stay outside the block. The USB side is seen only as two strobes: a received packet with its length, and a host ACK for a transmitted packet.

In the transmit direction (IN), each acknowledged DMA transfer pushes one word into the bank the DMA side owns. The word that makes the bank hold a maximum-size packet commits that bank. The committed bank is then offered to USB, and it is freed when the host ACKs it. In the receive direction (OUT), a packet from USB fills the free bank the USB side points at, and the DMA request stays up until that bank is drained. An option places the received byte count in front of the payload, so the local processor learns each packet's length from the first word it reads.

The sequencer has four states. SEQ_IDLE is the state after reset. On the first cycle with DMA enabled it moves to SEQ_IN_FILL when the direction is IN. For OUT it moves to SEQ_OUT_HDR when count insertion is on, and to SEQ_OUT_BODY when it is off. SEQ_IN_FILL stays in place, committing a bank every MAXP pushes. SEQ_OUT_HDR goes to SEQ_OUT_BODY after the count word of a non-empty packet. It stays in SEQ_OUT_HDR after the count word of an empty packet, which releases that bank. SEQ_OUT_BODY goes back to SEQ_OUT_HDR after the last payload word when insertion is on; otherwise it stays in SEQ_OUT_BODY. Direction and insertion are expected to be static while DMA is enabled.

Top module: `epb_dma_pacer`

## Requirements
- R1: After reset, dma_req and pkt_ready are 0, both banks are empty, and bank_dma and bank_usb are both 0.
- R2: In IN mode with DMA enabled, dma_req is 1 while the bank_dma bank is not committed. Each dma_ack while dma_req is 1 gives a fifo_push in the same cycle, aimed at bank_dma.
- R3: In IN mode, the MAXP-th push into a bank commits it. From the next cycle pkt_ready is 1 and bank_dma has toggled.
- R4: In IN mode, dma_req is 0 while both banks are committed.
- R5: In IN mode, usb_ack_rx while pkt_ready is 1 frees the bank_usb bank and toggles bank_usb, and dma_req returns if DMA was waiting. usb_ack_rx with no committed bank changes nothing.
- R6: In OUT mode, usb_pkt_rx stores usb_rx_len in the free bank_usb bank and toggles bank_usb. From the next cycle pkt_ready and dma_req are 1. A packet arriving while both banks are full is dropped, and bank_usb does not move.
- R7: In OUT mode without insertion, every acknowledged transfer gives fifo_pop, and dma_rdata equals fifo_rdata. After the packet's length in transfers, the bank is freed and bank_dma toggles.
- R8: In OUT mode with insertion, the first acknowledged transfer of each packet gives no fifo_pop and returns the byte count, zero-extended, on dma_rdata. The payload transfers follow as in R7.
- R9: In OUT mode, pkt_ready falls in the cycle after the last payload word is read if the other bank is empty. It stays 1 if the other bank holds a packet.
- R10: A zero-length received packet is freed by its count word when insertion is on. When insertion is off it is freed one cycle after it becomes the bank_dma bank, without raising dma_req.
- R11: With cfg_dma_en at 0, dma_req is 0, acknowledges move no data, and the word counts are kept. Re-enabling resumes the packet where it stopped.
- R12: dma_ack while dma_req is 0 gives neither fifo_push nor fifo_pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dma_en | input | 1 | DMA enable; 0 holds the request low and freezes progress |
| cfg_dir_in | input | 1 | 1 = IN (transmit), 0 = OUT (receive) |
| cfg_cnt_ins | input | 1 | Insert received byte count ahead of OUT payload |
| dma_req | output | 1 | DMA request to the local bus |
| dma_ack | input | 1 | DMA acknowledge; one word per cycle it is high with dma_req |
| dma_rdata | output | DW | Word returned to the DMA engine in OUT mode |
| fifo_rdata | input | DW | Payload word read from the bank_dma bank |
| fifo_push | output | 1 | Write the DMA word into the bank_dma bank |
| fifo_pop | output | 1 | Advance the read pointer of the bank_dma bank |
| bank_dma | output | 1 | Bank currently owned by the DMA side |
| bank_usb | output | 1 | Bank currently owned by the USB side |
| usb_pkt_rx | input | 1 | Strobe: a packet landed in the bank_usb bank |
| usb_rx_len | input | CNT_W | Byte count of the received packet |
| usb_ack_rx | input | 1 | Strobe: host ACKed the transmitted packet |
| pkt_ready | output | 1 | Packet-ready status (transmit in IN, receive in OUT) |

## Verification
The hardest situations to reach are the ones where both banks are busy. These are a third OUT packet arriving while two are still undrained, and a commit into the second bank while the first still waits for the host ACK. Random stimulus rarely lines these up. Directed sequences therefore fill both banks back to back before draining, and a short MAXP keeps each bank filling quickly. Disabling in the middle of a packet and zero-length packets with and without the count word are also driven directly. The random phase then mixes acknowledges, host events and enable toggles against a cycle model kept in the bench.

// File: rtl/epb_pkg.sv
package epb_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_IN_FILL,
        SEQ_OUT_HDR,
        SEQ_OUT_BODY
    } seq_state_t;
endpackage

// File: rtl/epb_bank_ctrl.sv
module epb_bank_ctrl #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_in,
    input  logic             usb_pkt_rx,
    input  logic [CNT_W-1:0] usb_rx_len,
    input  logic             usb_ack_rx,
    input  logic             dma_done,
    output logic             dma_bank,
    output logic             usb_bank,
    output logic             full_dma,
    output logic             full_usb,
    output logic [CNT_W-1:0] len_dma
);
    localparam int NBANK = 2;

    logic [NBANK-1:0] full;
    logic [CNT_W-1:0] len_q [NBANK];
    logic             dp, up;
    logic             usb_take, usb_free;

    assign usb_take = !dir_in && usb_pkt_rx && !full[up];
    assign usb_free = dir_in && usb_ack_rx && full[up];

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            logic set_b, clr_b;
            assign set_b = (dma_done && dir_in && dp == 1'(b)) || (usb_take && up == 1'(b));
            assign clr_b = (dma_done && !dir_in && dp == 1'(b)) || (usb_free && up == 1'(b));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    full[b]  <= 1'b0;
                    len_q[b] <= '0;
                end else begin
                    if (set_b)
                        full[b] <= 1'b1;
                    else if (clr_b)
                        full[b] <= 1'b0;
                    if (usb_take && up == 1'(b))
                        len_q[b] <= usb_rx_len;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp <= 1'b0;
            up <= 1'b0;
        end else begin
            dp <= dp ^ dma_done;
            up <= up ^ (usb_take | usb_free);
        end
    end

    assign dma_bank = dp;
    assign usb_bank = up;
    assign full_dma = full[dp];
    assign full_usb = full[up];
    assign len_dma  = len_q[dp];

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && dir_in) |-> !full[dp]);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !dir_in) |-> full[dp]);

    // R6
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_in && usb_pkt_rx && (&full) && !dma_done) |=> (&full) && $stable(up));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && usb_ack_rx && full[up] && !dma_done)
        |=> $countones(full) == $countones($past(full)) - 1);
endmodule

// File: rtl/epb_seq.sv
module epb_seq
    import epb_pkg::*;
#(
    parameter int MAXP  = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic             dir_in,
    input  logic             cnt_ins,
    input  logic             dma_ack,
    input  logic             full_dma,
    input  logic [CNT_W-1:0] len_dma,
    output logic             dma_req,
    output logic             fifo_push,
    output logic             fifo_pop,
    output logic             hdr_phase,
    output logic             dma_done
);
    localparam logic [CNT_W-1:0] LAST_IN = CNT_W'(MAXP - 1);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] wcnt, rcnt;
    logic             last_in, last_out, fire, zl_free;

    assign last_in  = (wcnt == LAST_IN);
    assign last_out = (rcnt == len_dma - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            wcnt  <= '0;
            rcnt  <= '0;
        end else begin
            state <= nxt;
            if (fifo_push)
                wcnt <= last_in ? '0 : wcnt + 1'b1;
            if (fifo_pop)
                rcnt <= last_out ? '0 : rcnt + 1'b1;
        end
    end

    always_comb begin
        dma_req   = 1'b0;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        hdr_phase = 1'b0;
        dma_done  = 1'b0;
        zl_free   = 1'b0;
        fire      = 1'b0;
        nxt       = state;
        unique case (state)
            SEQ_IDLE: begin
                if (dma_en)
                    nxt = dir_in ? SEQ_IN_FILL : (cnt_ins ? SEQ_OUT_HDR : SEQ_OUT_BODY);
            end
            SEQ_IN_FILL: begin
                dma_req   = dma_en && !full_dma;
                fire      = dma_req && dma_ack;
                fifo_push = fire;
                dma_done  = fire && last_in;
            end
            SEQ_OUT_HDR: begin
                hdr_phase = 1'b1;
                dma_req   = dma_en && full_dma;
                fire      = dma_req && dma_ack;
                if (fire) begin
                    if (len_dma == '0)
                        dma_done = 1'b1;
                    else
                        nxt = SEQ_OUT_BODY;
                end
            end
            SEQ_OUT_BODY: begin
                zl_free  = dma_en && full_dma && (len_dma == '0);
                dma_req  = dma_en && full_dma && (len_dma != '0);
                fire     = dma_req && dma_ack;
                fifo_pop = fire;
                dma_done = zl_free || (fire && last_out);
                if (fire && last_out)
                    nxt = cnt_ins ? SEQ_OUT_HDR : SEQ_OUT_BODY;
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    // R11
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> $stable(wcnt) && $stable(rcnt));

    // R3
    wcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> wcnt <= LAST_IN);

    // R8
    hdr_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OUT_HDR && dma_ack) |=> rcnt == $past(rcnt));
endmodule

// File: rtl/epb_dma_pacer.sv
module epb_dma_pacer #(
    parameter int MAXP = 64,
    parameter int DW   = 8,
    localparam int CNT_W = $clog2(MAXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dma_en,
    input  logic             cfg_dir_in,
    input  logic             cfg_cnt_ins,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic [DW-1:0]    dma_rdata,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             fifo_push,
    output logic             fifo_pop,
    output logic             bank_dma,
    output logic             bank_usb,
    input  logic             usb_pkt_rx,
    input  logic [CNT_W-1:0] usb_rx_len,
    input  logic             usb_ack_rx,
    output logic             pkt_ready
);
    logic             full_dma, full_usb, hdr_phase, dma_done;
    logic [CNT_W-1:0] len_dma;

    epb_bank_ctrl #(.CNT_W(CNT_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_in     (cfg_dir_in),
        .usb_pkt_rx (usb_pkt_rx),
        .usb_rx_len (usb_rx_len),
        .usb_ack_rx (usb_ack_rx),
        .dma_done   (dma_done),
        .dma_bank   (bank_dma),
        .usb_bank   (bank_usb),
        .full_dma   (full_dma),
        .full_usb   (full_usb),
        .len_dma    (len_dma)
    );

    epb_seq #(.MAXP(MAXP), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (cfg_dma_en),
        .dir_in    (cfg_dir_in),
        .cnt_ins   (cfg_cnt_ins),
        .dma_ack   (dma_ack),
        .full_dma  (full_dma),
        .len_dma   (len_dma),
        .dma_req   (dma_req),
        .fifo_push (fifo_push),
        .fifo_pop  (fifo_pop),
        .hdr_phase (hdr_phase),
        .dma_done  (dma_done)
    );

    assign dma_rdata = hdr_phase ? DW'(len_dma) : fifo_rdata;
    assign pkt_ready = cfg_dir_in ? full_usb : full_dma;

    // R6
    out_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && dma_req) |-> pkt_ready);

    // R3
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && $stable(cfg_dir_in) && $rose(pkt_ready)) |-> $past(fifo_push));

    // R12
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !dma_req) |-> !fifo_push && !fifo_pop);
endmodule

// File: tb/tb_epb_dma_pacer.sv
module tb_epb_dma_pacer;
    localparam int MAXP = 8;
    localparam int DW   = 8;
    localparam int CW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cfg_dma_en, cfg_dir_in, cfg_cnt_ins;
    logic dma_req, dma_ack, fifo_push, fifo_pop, bank_dma, bank_usb;
    logic usb_pkt_rx, usb_ack_rx, pkt_ready;
    logic [DW-1:0] dma_rdata, fifo_rdata;
    logic [CW-1:0] usb_rx_len;

    epb_dma_pacer #(.MAXP(MAXP), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_dir_in(cfg_dir_in),
        .cfg_cnt_ins(cfg_cnt_ins), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_rdata(dma_rdata), .fifo_rdata(fifo_rdata), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .bank_dma(bank_dma), .bank_usb(bank_usb),
        .usb_pkt_rx(usb_pkt_rx), .usb_rx_len(usb_rx_len), .usb_ack_rx(usb_ack_rx),
        .pkt_ready(pkt_ready)
    );

    int    checks = 0, errors = 0, cyc = 0;
    string cur_tag = "R1";

    // bench model: 0 idle, 1 in fill, 2 out count word, 3 out payload
    int mst, m_wc, m_rc;
    int m_len [2];
    bit m_full [2];
    bit m_dp, m_up;
    bit e_req, e_push, e_pop, e_rdy;
    int e_rdata;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mst = 0; m_wc = 0; m_rc = 0; m_dp = 0; m_up = 0;
        for (int i = 0; i < 2; i++) begin m_full[i] = 0; m_len[i] = 0; end
    endtask

    task automatic model_eval();
        bit en = cfg_dma_en;
        case (mst)
            1: e_req = en && !m_full[m_dp];
            2: e_req = en && m_full[m_dp];
            3: e_req = en && m_full[m_dp] && m_len[m_dp] != 0;
            default: e_req = 0;
        endcase
        e_push  = e_req && dma_ack && mst == 1;
        e_pop   = e_req && dma_ack && mst == 3;
        e_rdata = (mst == 2) ? m_len[m_dp] : int'(fifo_rdata);
        e_rdy   = cfg_dir_in ? m_full[m_up] : m_full[m_dp];
    endtask

    task automatic model_update();
        bit fire = e_req && dma_ack;
        bit done = 0;
        int nst = mst;
        case (mst)
            0: if (cfg_dma_en) nst = cfg_dir_in ? 1 : (cfg_cnt_ins ? 2 : 3);
            1: if (fire) begin
                   if (m_wc == MAXP - 1) begin done = 1; m_wc = 0; end else m_wc++;
               end
            2: if (fire) begin
                   if (m_len[m_dp] == 0) done = 1; else nst = 3;
               end
            3: if (cfg_dma_en && m_full[m_dp] && m_len[m_dp] == 0) done = 1;
               else if (fire) begin
                   if (m_rc == m_len[m_dp] - 1) begin
                       done = 1; m_rc = 0; nst = cfg_cnt_ins ? 2 : 3;
                   end else m_rc++;
               end
            default: ;
        endcase
        if (cfg_dir_in) begin
            if (usb_ack_rx && m_full[m_up]) begin m_full[m_up] = 0; m_up = !m_up; end
        end else if (usb_pkt_rx && !m_full[m_up]) begin
            m_full[m_up] = 1; m_len[m_up] = int'(usb_rx_len); m_up = !m_up;
        end
        if (done) begin m_full[m_dp] = cfg_dir_in; m_dp = !m_dp; end
        mst = nst;
    endtask

    task automatic step(bit ack, bit rx, int rlen, bit hack);
        dma_ack = ack; usb_pkt_rx = rx; usb_rx_len = CW'(rlen); usb_ack_rx = hack;
        fifo_rdata = DW'($urandom);
        #1;
        model_eval();
        chk(cur_tag, "dma_req", dma_req, e_req);
        chk(cur_tag, "fifo_push", fifo_push, e_push);
        chk(cur_tag, "fifo_pop", fifo_pop, e_pop);
        chk(cur_tag, "dma_rdata", int'(dma_rdata), e_rdata);
        chk(cur_tag, "pkt_ready", pkt_ready, e_rdy);
        chk(cur_tag, "bank_dma", bank_dma, m_dp);
        chk(cur_tag, "bank_usb", bank_usb, m_up);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic do_reset(bit dir, bit ins);
        rst_n = 0; cfg_dma_en = 0; cfg_dir_in = dir; cfg_cnt_ins = ins;
        dma_ack = 0; usb_pkt_rx = 0; usb_rx_len = '0; usb_ack_rx = 0; fifo_rdata = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset(1, 0);
        #1;
        chk("R1", "dma_req", dma_req, 0);
        chk("R1", "pkt_ready", pkt_ready, 0);
        chk("R1", "bank_dma", bank_dma, 0);
        chk("R1", "bank_usb", bank_usb, 0);
        step(0, 0, 0, 0);

        // IN: fill, commit, both full, release
        cfg_dma_en = 1; cur_tag = "R2";
        step(0, 0, 0, 0);
        for (int i = 0; i < MAXP; i++) step(1, 0, 0, 0);
        chk("R3", "pkt_ready", pkt_ready, 1);
        chk("R3", "bank_dma", bank_dma, 1);
        cur_tag = "R4";
        for (int i = 0; i < MAXP; i++) step(1, 0, 0, 0);
        chk("R4", "dma_req", dma_req, 0);
        cur_tag = "R12";
        step(1, 0, 0, 0);
        chk("R12", "fifo_push", fifo_push, 0);
        cur_tag = "R5";
        step(0, 0, 0, 1);
        chk("R5", "dma_req", dma_req, 1);
        chk("R5", "bank_usb", bank_usb, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R5", "bank_usb", bank_usb, 0);
        chk("R5", "pkt_ready", pkt_ready, 0);

        // OUT without count word
        do_reset(0, 0); cfg_dma_en = 1; cur_tag = "R6";
        step(0, 0, 0, 0);
        step(0, 1, 3, 0);
        chk("R6", "pkt_ready", pkt_ready, 1);
        chk("R6", "dma_req", dma_req, 1);
        step(0, 1, 5, 0);
        step(0, 1, 2, 0);
        chk("R6", "bank_usb", bank_usb, 0);
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        chk("R9", "pkt_ready", pkt_ready, 1);
        chk("R7", "bank_dma", bank_dma, 1);
        cur_tag = "R9";
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        chk("R9", "pkt_ready", pkt_ready, 0);

        // disable in the middle of a packet
        cur_tag = "R11";
        step(0, 1, 4, 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        cfg_dma_en = 0;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        chk("R11", "dma_req", dma_req, 0);
        chk("R11", "pkt_ready", pkt_ready, 1);
        cfg_dma_en = 1;
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk("R11", "pkt_ready", pkt_ready, 0);

        // count word insertion and empty packets
        do_reset(0, 1); cfg_dma_en = 1; cur_tag = "R8";
        step(0, 0, 0, 0);
        step(0, 1, 2, 0);
        dma_ack = 1; #1;
        chk("R8", "dma_rdata", int'(dma_rdata), 2);
        chk("R8", "fifo_pop", fifo_pop, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk("R8", "pkt_ready", pkt_ready, 0);
        cur_tag = "R10";
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        chk("R10", "pkt_ready", pkt_ready, 0);
        do_reset(0, 0); cfg_dma_en = 1;
        step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        chk("R10", "dma_req", dma_req, 0);
        step(0, 0, 0, 0);
        chk("R10", "pkt_ready", pkt_ready, 0);

        // random mix
        for (int r = 0; r < 12; r++) begin
            bit d = r[0];
            bit ins = r[1];
            do_reset(d, ins); cfg_dma_en = 1;
            cur_tag = d ? "R4" : (ins ? "R8" : "R7");
            for (int i = 0; i < 400; i++) begin
                if ($urandom % 20 == 0) cfg_dma_en = !cfg_dma_en;
                step($urandom % 2 == 0, $urandom % 4 == 0,
                     int'($urandom % (MAXP + 1)), $urandom % 3 == 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule